// File: doc/BRIEF.md
# GSAT Local Search Controller

This block steers a greedy local search for a satisfying assignment of a Boolean formula in conjunctive normal form. It does not store the formula itself. An external clause tracker keeps per-clause counters and reports how many clauses are satisfied. On request, the tracker also reports the change in that count that flipping one variable would cause. The controller owns the current assignment and the attempt counter, and it drives the search through four request lines to the tracker.

Each attempt runs in the same order:

1. Draw a fresh assignment, one bit per cycle, from an external random-bit source.
2. Load that assignment into the tracker, one variable at a time.
3. Check whether every clause is satisfied.
4. Otherwise, probe every variable for its exact flip gain.
5. If the best gain is positive, commit the flip of the best variable and return to the check.

When the best gain is zero or negative, the attempt is abandoned and a new one starts. The search ends on success, or when the allowed number of attempts is used up. Either way the controller raises `done_o` and holds its result until the next start.

Top module: `gsat_ctrl`

## Requirements
- R1: During and right after reset, `done_o`, `success_o` and all four tracker requests are low, and `assign_o` is all zeros.
- R2: A start accepted while idle or done begins an attempt. `trk_clear_o` pulses for exactly one cycle. Over `NUM_VARS` consecutive cycles, bit i of `assign_o` takes the value `rand_bit_i` had in the i-th of those cycles, counting from 0.
- R3: After the draw, `trk_load_o` requests variables 0 to `NUM_VARS`-1 in ascending order. Each request is held with a stable `trk_var_o` until `trk_ack_i`, and `trk_val_o` equals that variable's bit of `assign_o`.
- R4: One cycle after the last load is acknowledged, and one cycle after each committed flip is acknowledged, `trk_sat_cnt_i` is compared with `num_clauses_i`. If they are equal, `done_o` and `success_o` go high one cycle later, no probe is issued, and `done_o`, `success_o` and `assign_o` hold until the next start.
- R5: If that comparison fails, `trk_probe_o` requests every variable in ascending order. Each request is held with a stable `trk_var_o` until `trk_ack_i`, and `trk_gain_i` is read in the acknowledge cycle.
- R6: The probe of variable 0 always becomes the best candidate. A later probe replaces it when its gain is strictly larger, or when its gain is equal and `rand_bit_i` is 1 in its acknowledge cycle.
- R7: If the best gain is positive, `trk_flip_o` requests the best variable and is held until `trk_ack_i`. On that acknowledge, the variable's bit in `assign_o` is inverted.
- R8: If the best gain is zero or negative, the attempt counter increases by one. Unless the limit is then reached, a new attempt begins at once with a fresh clear and draw.
- R9: When the attempt counter reaches the limit captured at start, `done_o` goes high with `success_o` low. A limit of 0 behaves as 1.
- R10: At most one of `trk_clear_o`, `trk_load_o`, `trk_probe_o` and `trk_flip_o` is high in any cycle.
- R11: `start_i` has no effect while a search is in progress.
- R12: Whenever `success_o` is high, `assign_o` satisfies every clause of the formula held by the tracker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a search when idle or done |
| max_attempts_i | input | ATT_W | Allowed attempts, captured at start (0 acts as 1) |
| rand_bit_i | input | 1 | Random bit for assignment draws and tie breaks |
| num_clauses_i | input | CLS_W | Total clause count of the formula |
| done_o | output | 1 | Search finished; held until next start |
| success_o | output | 1 | Finished with a satisfying assignment |
| assign_o | output | NUM_VARS | Current assignment, bit i is variable i |
| trk_clear_o | output | 1 | One-cycle clear of the tracker counters |
| trk_load_o | output | 1 | Request: add a variable's contribution |
| trk_probe_o | output | 1 | Request: report flip gain of a variable |
| trk_flip_o | output | 1 | Request: commit flip of a variable |
| trk_var_o | output | VAR_W | Variable index of the active request |
| trk_val_o | output | 1 | Value of the variable being loaded |
| trk_ack_i | input | 1 | Tracker completed the active request |
| trk_gain_i | input | GAIN_W | Signed flip gain, valid with the probe acknowledge |
| trk_sat_cnt_i | input | CLS_W | Number of clauses currently satisfied |

## Verification
On every cycle, the assertions check the request protocol:
- at most one request is active (R10);
- every load, probe and flip stays up with a fixed index until acknowledged (R3, R5, R7);
- the clear is a single-cycle pulse (R2);
- success never appears without done (R9);
- the finished result does not move while start is low (R4).

The bench alone shows the search itself:
- the order of the random draw (R2);
- the tie breaks driven by the random bit (R6);
- the attempt accounting and its zero limit (R8, R9);
- that a mid-search start is ignored (R11);
- that a reported success really satisfies the formula (R12).

It does this by running a behavioural clause tracker against three formulas: one trivially true, one satisfiable, one unsatisfiable. A cycle-level reference model is compared against the outputs throughout.

// File: rtl/gsat_pkg.sv
// Shared definitions for the GSAT local search controller.
// Assumes nothing beyond a synthesizable SystemVerilog flow.
package gsat_pkg;

    // Controller phases; ST_DONE is the terminal phase of a run.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_LOAD,
        ST_CHECK,
        ST_PROBE,
        ST_PICK,
        ST_DONE
    } gsat_st_e;

endpackage

// File: rtl/gsat_assign_reg.sv
// Assignment register: one flop per variable. Each bit can be written
// with a random draw or inverted by a committed flip.
// Assumes write and toggle are never requested in the same cycle.
module gsat_assign_reg #(
    parameter int NUM_VARS = 8,
    parameter int VAR_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [VAR_W-1:0]    wr_idx_i,
    input  logic                wr_bit_i,
    input  logic                tog_en_i,
    input  logic [VAR_W-1:0]    tog_idx_i,
    output logic [NUM_VARS-1:0] vec_o
);

    for (genvar i = 0; i < NUM_VARS; i++) begin : g_bit
        // Per-variable storage: draw write has priority over flip.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_o[i] <= 1'b0;
            end else if (wr_en_i && (wr_idx_i == VAR_W'(i))) begin
                vec_o[i] <= wr_bit_i;
            end else if (tog_en_i && (tog_idx_i == VAR_W'(i))) begin
                vec_o[i] <= ~vec_o[i];
            end
        end
    end

endmodule

// File: rtl/gsat_best_pick.sv
// Running maximum over probed flip gains, with random tie breaking.
// The first candidate of a sweep always loads the register.
// Assumes gains arrive one per probe acknowledge.
module gsat_best_pick #(
    parameter int VAR_W  = 3,
    parameter int GAIN_W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     take_i,
    input  logic                     first_i,
    input  logic [VAR_W-1:0]         cand_idx_i,
    input  logic signed [GAIN_W-1:0] cand_gain_i,
    input  logic                     rand_bit_i,
    output logic [VAR_W-1:0]         best_idx_o,
    output logic signed [GAIN_W-1:0] best_gain_o
);

    logic better;
    logic tie;

    // Replacement decision for the current candidate.
    always_comb begin
        better = cand_gain_i > best_gain_o;
        tie    = (cand_gain_i == best_gain_o) && rand_bit_i;
    end

    // Best candidate register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_idx_o  <= '0;
            best_gain_o <= '0;
        end else if (take_i && (first_i || better || tie)) begin
            best_idx_o  <= cand_idx_i;
            best_gain_o <= cand_gain_i;
        end
    end

endmodule

// File: rtl/gsat_attempt_ctr.sv
// Attempt counter and its limit captured at search start.
// A limit of zero is stored as one. last_o tells whether the next
// increment reaches the limit.
module gsat_attempt_ctr #(
    parameter int ATT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [ATT_W-1:0] limit_i,
    input  logic             inc_i,
    output logic             last_o
);

    logic [ATT_W-1:0] cnt_q;
    logic [ATT_W-1:0] lim_q;

    // Counter and limit storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= ATT_W'(1);
        end else if (load_i) begin
            cnt_q <= '0;
            lim_q <= (limit_i == '0) ? ATT_W'(1) : limit_i;
        end else if (inc_i) begin
            cnt_q <= cnt_q + ATT_W'(1);
        end
    end

    // Limit test on the incremented count, one bit wider to avoid wrap.
    always_comb begin
        last_o = ({1'b0, cnt_q} + (ATT_W+1)'(1)) >= {1'b0, lim_q};
    end

endmodule

// File: rtl/gsat_fsm.sv
// Phase sequencer of the search: draw, load, check, probe sweep,
// pick/commit, finish. Keeps the variable index and the success flag.
// Assumes tracker requests are acknowledged with a one-cycle ack.
module gsat_fsm
    import gsat_pkg::*;
#(
    parameter int NUM_VARS = 8,
    parameter int VAR_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ack_i,
    input  logic             sat_hit_i,
    input  logic             gain_pos_i,
    input  logic             last_try_i,
    output gsat_st_e         state_o,
    output logic [VAR_W-1:0] idx_o,
    output logic             success_o
);

    localparam logic [VAR_W-1:0] LAST_IDX = VAR_W'(NUM_VARS - 1);

    logic at_last;

    // Final-variable flag for all index sweeps.
    always_comb begin
        at_last = (idx_o == LAST_IDX);
    end

    // Phase, index and success registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o   <= ST_IDLE;
            idx_o     <= '0;
            success_o <= 1'b0;
        end else begin
            unique case (state_o)
                ST_IDLE, ST_DONE: begin
                    if (start_i) begin
                        state_o   <= ST_INIT;
                        idx_o     <= '0;
                        success_o <= 1'b0;
                    end
                end
                ST_INIT: begin
                    if (at_last) begin
                        state_o <= ST_LOAD;
                        idx_o   <= '0;
                    end else begin
                        idx_o <= idx_o + VAR_W'(1);
                    end
                end
                ST_LOAD: begin
                    if (ack_i) begin
                        if (at_last) begin
                            state_o <= ST_CHECK;
                        end else begin
                            idx_o <= idx_o + VAR_W'(1);
                        end
                    end
                end
                ST_CHECK: begin
                    if (sat_hit_i) begin
                        state_o   <= ST_DONE;
                        success_o <= 1'b1;
                    end else begin
                        state_o <= ST_PROBE;
                        idx_o   <= '0;
                    end
                end
                ST_PROBE: begin
                    if (ack_i) begin
                        if (at_last) begin
                            state_o <= ST_PICK;
                        end else begin
                            idx_o <= idx_o + VAR_W'(1);
                        end
                    end
                end
                ST_PICK: begin
                    if (gain_pos_i) begin
                        if (ack_i) begin
                            state_o <= ST_CHECK;
                        end
                    end else if (last_try_i) begin
                        state_o <= ST_DONE;
                    end else begin
                        state_o <= ST_INIT;
                        idx_o   <= '0;
                    end
                end
                default: begin
                    state_o <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/gsat_ctrl.sv
// Top of the GSAT local search controller. Runs greedy single-flip
// search over an external clause tracker, with random restarts.
// Assumes the tracker answers each request with a one-cycle ack, reports
// the probe gain with that ack, and updates its satisfied count by the
// cycle after each load or flip ack.
module gsat_ctrl
    import gsat_pkg::*;
#(
    parameter int  NUM_VARS = 8,
    parameter int  CLS_W    = 10,
    parameter int  ATT_W    = 8,
    localparam int VAR_W    = (NUM_VARS > 2) ? $clog2(NUM_VARS) : 1,
    localparam int GAIN_W   = CLS_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [ATT_W-1:0]         max_attempts_i,
    input  logic                     rand_bit_i,
    input  logic [CLS_W-1:0]         num_clauses_i,
    output logic                     done_o,
    output logic                     success_o,
    output logic [NUM_VARS-1:0]      assign_o,
    output logic                     trk_clear_o,
    output logic                     trk_load_o,
    output logic                     trk_probe_o,
    output logic                     trk_flip_o,
    output logic [VAR_W-1:0]         trk_var_o,
    output logic                     trk_val_o,
    input  logic                     trk_ack_i,
    input  logic signed [GAIN_W-1:0] trk_gain_i,
    input  logic [CLS_W-1:0]         trk_sat_cnt_i
);

    gsat_st_e                  state;
    logic [VAR_W-1:0]          idx;
    logic [VAR_W-1:0]          best_idx;
    logic signed [GAIN_W-1:0]  best_gain;
    logic                      sat_hit;
    logic                      gain_pos;
    logic                      last_try;
    logic                      run_start;

    // Condition flags feeding the sequencer.
    always_comb begin
        sat_hit   = (trk_sat_cnt_i == num_clauses_i);
        gain_pos  = best_gain > 0;
        run_start = start_i && ((state == ST_IDLE) || (state == ST_DONE));
    end

    // Tracker request decode from the current phase.
    always_comb begin
        trk_clear_o = (state == ST_INIT) && (idx == '0);
        trk_load_o  = (state == ST_LOAD);
        trk_probe_o = (state == ST_PROBE);
        trk_flip_o  = (state == ST_PICK) && gain_pos;
        trk_var_o   = (state == ST_PICK) ? best_idx : idx;
        trk_val_o   = assign_o[idx];
        done_o      = (state == ST_DONE);
    end

    gsat_fsm #(
        .NUM_VARS (NUM_VARS),
        .VAR_W    (VAR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ack_i      (trk_ack_i),
        .sat_hit_i  (sat_hit),
        .gain_pos_i (gain_pos),
        .last_try_i (last_try),
        .state_o    (state),
        .idx_o      (idx),
        .success_o  (success_o)
    );

    gsat_assign_reg #(
        .NUM_VARS (NUM_VARS),
        .VAR_W    (VAR_W)
    ) u_assign (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (state == ST_INIT),
        .wr_idx_i  (idx),
        .wr_bit_i  (rand_bit_i),
        .tog_en_i  (trk_flip_o && trk_ack_i),
        .tog_idx_i (best_idx),
        .vec_o     (assign_o)
    );

    gsat_best_pick #(
        .VAR_W  (VAR_W),
        .GAIN_W (GAIN_W)
    ) u_best (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (trk_probe_o && trk_ack_i),
        .first_i     (idx == '0),
        .cand_idx_i  (idx),
        .cand_gain_i (trk_gain_i),
        .rand_bit_i  (rand_bit_i),
        .best_idx_o  (best_idx),
        .best_gain_o (best_gain)
    );

    gsat_attempt_ctr #(
        .ATT_W (ATT_W)
    ) u_att (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (run_start),
        .limit_i (max_attempts_i),
        .inc_i   ((state == ST_PICK) && !gain_pos),
        .last_o  (last_try)
    );

endmodule

// File: rtl/gsat_ctrl_chk.sv
// Protocol checker for gsat_ctrl, attached by bind. Watches the tracker
// handshake and the held result at the ports.
module gsat_ctrl_chk #(
    parameter int NUM_VARS = 8,
    parameter int VAR_W    = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                trk_ack_i,
    input logic                trk_clear_o,
    input logic                trk_load_o,
    input logic                trk_probe_o,
    input logic                trk_flip_o,
    input logic [VAR_W-1:0]    trk_var_o,
    input logic                done_o,
    input logic                success_o,
    input logic [NUM_VARS-1:0] assign_o
);

    a_r10_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trk_clear_o, trk_load_o, trk_probe_o, trk_flip_o}));

    a_r2_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trk_clear_o |=> !trk_clear_o);

    a_r3_load_held: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_load_o && !trk_ack_i) |=> (trk_load_o && $stable(trk_var_o)));

    a_r5_probe_held: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_probe_o && !trk_ack_i) |=> (trk_probe_o && $stable(trk_var_o)));

    a_r7_flip_held: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_flip_o && !trk_ack_i) |=> (trk_flip_o && $stable(trk_var_o)));

    a_r9_success_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        success_o |-> done_o);

    a_r4_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(success_o) && $stable(assign_o)));

endmodule

bind gsat_ctrl gsat_ctrl_chk #(
    .NUM_VARS (NUM_VARS),
    .VAR_W    (VAR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .trk_ack_i   (trk_ack_i),
    .trk_clear_o (trk_clear_o),
    .trk_load_o  (trk_load_o),
    .trk_probe_o (trk_probe_o),
    .trk_flip_o  (trk_flip_o),
    .trk_var_o   (trk_var_o),
    .done_o      (done_o),
    .success_o   (success_o),
    .assign_o    (assign_o)
);

// File: tb/gsat_ctrl_bench.sv
// Bench for gsat_ctrl: a behavioural clause tracker holding one of three
// formulas, a cycle-level reference model compared on every clock, and
// scenario checks on the results.
module gsat_ctrl_bench;

    localparam int NV     = 8;
    localparam int CLS_W  = 10;
    localparam int ATT_W  = 8;
    localparam int VAR_W  = 3;
    localparam int GAIN_W = CLS_W + 1;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     start = 1'b0;
    logic [ATT_W-1:0]         max_att = '0;
    logic                     rbit;
    logic [CLS_W-1:0]         ncls;
    logic                     done, success;
    logic [NV-1:0]            asg;
    logic                     t_clear, t_load, t_probe, t_flip, t_val;
    logic [VAR_W-1:0]         t_var;
    logic                     t_ack;
    logic signed [GAIN_W-1:0] t_gain;
    logic [CLS_W-1:0]         t_sat;

    int checks = 0;
    int fails  = 0;
    int sel    = 2;
    int cycles = 0;
    int n_clear = 0;
    int n_probe = 0;

    always #2.5 clk = ~clk;

    gsat_ctrl #(.NUM_VARS(NV), .CLS_W(CLS_W), .ATT_W(ATT_W)) u_gsat_ctrl (
        .clk (clk), .rst_n (rst_n), .start_i (start), .max_attempts_i (max_att),
        .rand_bit_i (rbit), .num_clauses_i (ncls), .done_o (done),
        .success_o (success), .assign_o (asg), .trk_clear_o (t_clear),
        .trk_load_o (t_load), .trk_probe_o (t_probe), .trk_flip_o (t_flip),
        .trk_var_o (t_var), .trk_val_o (t_val), .trk_ack_i (t_ack),
        .trk_gain_i (t_gain), .trk_sat_cnt_i (t_sat)
    );

    // Formula storage: {positive mask, negative mask}, bit i = variable i.
    function automatic logic [15:0] clause(int s, int k);
        case (s)
            0: case (k)
                   0: return {8'h03, 8'h00};
                   1: return {8'h04, 8'h02};
                   2: return {8'h04, 8'h08};
                   3: return {8'h18, 8'h00};
                   4: return {8'h20, 8'h10};
                   5: return {8'h60, 8'h00};
                   6: return {8'h80, 8'h40};
                   7: return {8'h80, 8'h01};
                   8: return {8'h2A, 8'h00};
                   default: return {8'h40, 8'h14};
               endcase
            1: case (k)
                   0: return {8'h01, 8'h00};
                   1: return {8'h00, 8'h01};
                   default: return {8'h06, 8'h00};
               endcase
            default: return {8'h01, 8'h01};
        endcase
    endfunction

    function automatic int cls_total(int s);
        return (s == 0) ? 10 : (s == 1) ? 3 : 1;
    endfunction

    function automatic int count_sat(int s, logic [NV-1:0] a, logic [NV-1:0] ld);
        int n = 0;
        for (int k = 0; k < cls_total(s); k++) begin
            logic [15:0] c = clause(s, k);
            if (((c[15:8] & a & ld) != 0) || ((c[7:0] & ~a & ld) != 0)) n++;
        end
        return n;
    endfunction

    // Random source: 16-bit LFSR stepping on each rising edge.
    logic [15:0] lfsr;
    always @(posedge clk) begin
        if (!rst_n) lfsr <= 16'hACE1;
        else lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    assign rbit = lfsr[0];

    // Behavioural clause tracker answering each request after one cycle.
    logic [NV-1:0] ta, tld;
    always @(posedge clk) begin
        if (!rst_n) begin
            t_ack <= 1'b0; ta <= '0; tld <= '0; t_gain <= '0;
        end else if (t_clear) begin
            t_ack <= 1'b0; ta <= '0; tld <= '0;
        end else if (t_ack) begin
            t_ack <= 1'b0;
        end else if (t_load) begin
            ta[t_var] <= t_val; tld[t_var] <= 1'b1; t_ack <= 1'b1;
        end else if (t_probe) begin
            t_gain <= GAIN_W'(count_sat(sel, ta ^ (NV'(1) << t_var), tld) - count_sat(sel, ta, tld));
            t_ack <= 1'b1;
        end else if (t_flip) begin
            ta[t_var] <= ~ta[t_var]; t_ack <= 1'b1;
        end
    end
    assign t_sat = CLS_W'(count_sat(sel, ta, tld));
    assign ncls  = CLS_W'(cls_total(sel));

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model: phase codes 0 idle,1 draw,2 load,3 check,4 probe,5 pick,6 done.
    int m_st = 0, m_idx = 0, m_bidx = 0, m_bgain = 0, m_att = 0, m_lim = 1;
    logic [NV-1:0] m_asg = '0;
    bit m_succ = 0;

    always @(negedge clk) begin
        bit e_clear, e_load, e_probe, e_flip;
        int e_var;
        e_clear = (m_st == 1) && (m_idx == 0);
        e_load  = (m_st == 2);
        e_probe = (m_st == 4);
        e_flip  = (m_st == 5) && (m_bgain > 0);
        e_var   = (m_st == 5) ? m_bidx : m_idx;
        if (t_clear) n_clear++;
        if (t_probe && t_ack) n_probe++;
        chk(done == (m_st == 6), "R4/R9", "done_o", int'(done), int'(m_st == 6));
        chk(success == m_succ, "R4/R9", "success_o", int'(success), int'(m_succ));
        chk(asg == m_asg, "R2/R7", "assign_o", int'(asg), int'(m_asg));
        chk(t_clear == e_clear, "R2", "trk_clear_o", int'(t_clear), int'(e_clear));
        chk(t_load == e_load, "R3", "trk_load_o", int'(t_load), int'(e_load));
        chk(t_probe == e_probe, "R5", "trk_probe_o", int'(t_probe), int'(e_probe));
        chk(t_flip == e_flip, "R7", "trk_flip_o", int'(t_flip), int'(e_flip));
        if (e_load || e_probe || e_flip)
            chk(int'(t_var) == e_var, "R6", "trk_var_o", int'(t_var), e_var);
        if (e_load)
            chk(t_val == m_asg[m_idx], "R3", "trk_val_o", int'(t_val), int'(m_asg[m_idx]));
        // Advance the model to the state expected after the next edge.
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_bidx = 0; m_bgain = 0; m_att = 0; m_lim = 1;
            m_asg = '0; m_succ = 0;
        end else begin
            case (m_st)
                0, 6: if (start) begin
                    m_st = 1; m_idx = 0; m_succ = 0; m_att = 0;
                    m_lim = (max_att == 0) ? 1 : int'(max_att);
                end
                1: begin
                    m_asg[m_idx] = rbit;
                    if (m_idx == NV - 1) begin m_st = 2; m_idx = 0; end
                    else m_idx++;
                end
                2: if (t_ack) begin
                    if (m_idx == NV - 1) m_st = 3; else m_idx++;
                end
                3: if (int'(t_sat) == int'(ncls)) begin m_st = 6; m_succ = 1; end
                   else begin m_st = 4; m_idx = 0; end
                4: if (t_ack) begin
                    if (m_idx == 0 || int'(t_gain) > m_bgain ||
                        (int'(t_gain) == m_bgain && rbit)) begin
                        m_bgain = int'(t_gain); m_bidx = m_idx;
                    end
                    if (m_idx == NV - 1) m_st = 5; else m_idx++;
                end
                5: if (m_bgain > 0) begin
                    if (t_ack) begin m_asg[m_bidx] = ~m_asg[m_bidx]; m_st = 3; end
                end else begin
                    m_att++;
                    if (m_att >= m_lim) m_st = 6;
                    else begin m_st = 1; m_idx = 0; end
                end
                default: m_st = 0;
            endcase
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected done", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic run(int s, int lim);
        sel = s;
        max_att = ATT_W'(lim);
        n_clear = 0;
        n_probe = 0;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        do @(negedge clk); while (!done);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1: reset values at the ports.
        chk(!done && !success && asg == '0, "R1", "reset outputs", int'(asg), 0);
        chk(!(t_clear | t_load | t_probe | t_flip), "R1", "reset requests",
            int'({t_clear, t_load, t_probe, t_flip}), 0);
        rst_n = 1'b1;

        // R4: a tautology finishes right after loading, without probing.
        run(2, 3);
        chk(success == 1'b1, "R4", "immediate success", int'(success), 1);
        chk(n_probe == 0, "R4", "probes before success", n_probe, 0);
        repeat (10) @(negedge clk);
        chk(done && success, "R4", "result held", int'(done && success), 1);

        // R11/R12: satisfiable formula, with a start pulse mid-search.
        sel = 0; max_att = 8'd6; n_clear = 0;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        repeat (20) @(posedge clk);
        #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        do @(negedge clk); while (!done);
        chk(n_clear >= 1, "R11", "attempts after mid start", n_clear, 1);
        if (success)
            chk(count_sat(0, asg, '1) == 10, "R12", "clauses satisfied",
                count_sat(0, asg, '1), 10);

        // R8/R9: unsatisfiable formula uses exactly the allowed attempts.
        run(1, 2);
        chk(success == 1'b0, "R9", "failure flag", int'(success), 0);
        chk(n_clear == 2, "R8", "attempts run", n_clear, 2);

        // R9: limit of zero acts as one attempt.
        run(1, 0);
        chk(success == 1'b0, "R9", "zero limit flag", int'(success), 0);
        chk(n_clear == 1, "R9", "zero limit attempts", n_clear, 1);

        // R12: another satisfiable run from a fresh draw.
        run(0, 10);
        if (success)
            chk(count_sat(0, asg, '1) == 10, "R12", "clauses satisfied 2",
                count_sat(0, asg, '1), 10);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule